// File: doc/BRIEF.md
# Operand-2 Shifter

This unit forms the second source operand of a 32-bit data-processing instruction. It also computes the carry produced by the shift. It receives the low twelve bits of the instruction word, the immediate-mode flag, the value of the register to be shifted and the low byte of the register that may hold a shift amount. It also receives the current carry flag, the flag-update request and a code saying what the operand is for.

In immediate mode the unit rotates an 8-bit constant right by an even amount. In register mode it applies one of four shift kinds to the register value. The amount comes either from a 5-bit instruction field or from the amount register's low byte.

The result is registered. One clock edge after the inputs are presented, the unit shows three outputs:
- the operand;
- the shifter carry;
- a carry-valid flag, which tells the flag logic whether that carry may be written to the carry flag.

Top module: `o2_shifter`

## Requirements
- R1: With `immFlag` = 1, `operand` is `opField[7:0]` rotated right by twice `opField[11:8]`. `carryOut` equals `carryIn` when `opField[11:8]` is zero, and otherwise equals bit 31 of the rotated result.
- R2: With `immFlag` = 0, `opField[6:5]` selects the shift kind: 00 shift left, 01 logical shift right, 10 arithmetic shift right, 11 rotate right.
- R3: With `opField[4]` = 0 the shift amount is `opField[11:7]`. With `opField[4]` = 1 it is `rsByte`. The value shifted is always `rmValue`.
- R4: A shift amount of zero from either source gives `operand` = `rmValue` and `carryOut` = `carryIn`, for every shift kind.
- R5: For amounts 1 to 31 the shifts give their usual results. `carryOut` is the last bit shifted out; for rotate right this is bit 31 of the result.
- R6: Shift left by exactly 32 gives zero with carry `rmValue[0]`. Logical shift right by exactly 32 gives zero with carry `rmValue[31]`. Either logical shift by more than 32 gives zero with carry 0.
- R7: Arithmetic shift right by 32 or more gives 32 copies of `rmValue[31]`, with carry `rmValue[31]`.
- R8: Rotate right by a register amount uses the amount modulo 32. A nonzero multiple of 32 leaves `rmValue` unchanged, with carry `rmValue[31]`.
- R9: `useKind` encodes 00 ordinary data operation, 01 test-type operation, 10 address offset, 11 reserved. `carryValid` equals `setFlags` for 00, is always 1 for 01, and is always 0 for 10 and 11.
- R10: All three outputs are 0 while `rstN` is low. After reset they change only at a rising clock edge, showing the result for the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opField | input | 12 | Operand field of the instruction word, bits 11:0 |
| immFlag | input | 1 | Selects the rotated 8-bit constant |
| rmValue | input | 32 | Value of the register to be shifted |
| rsByte | input | 8 | Low byte of the shift-amount register |
| carryIn | input | 1 | Current carry flag |
| setFlags | input | 1 | Flag-update request of the instruction |
| useKind | input | 2 | What the operand is for (see R9) |
| operand | output | 32 | Registered second operand |
| carryOut | output | 1 | Registered shifter carry |
| carryValid | output | 1 | Carry may be committed to the flag |

## Verification
The bench targets the amount boundaries 0, 31, 32, 33 and large register amounts, where a design that reduced the amount modulo 32 for logical shifts would return a shifted value instead of zero. It also checks a wrong carry bit at exactly 32. Rotates by 32, 64 and 36 expose a design that zeroes the value or fails to wrap the amount. Zero amounts with both carry polarities catch a design that forces the carry instead of passing the flag through. The commit matrix catches a test-type operation that forgets to commit, and an address-offset use that leaks its carry into the flags.

// File: rtl/o2_pkg.sv
package o2_pkg;

  localparam int AMT_W = 8;  // register-sourced shift amount width
  localparam int ROT_W = 4;  // immediate rotate field width

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shiftKind_e;

  typedef enum logic [1:0] {
    USE_ALU  = 2'b00,
    USE_TEST = 2'b01,
    USE_ADDR = 2'b10,
    USE_RSVD = 2'b11
  } useKind_e;

  typedef struct packed {
    logic             immMode;
    logic [ROT_W-1:0] rotField;
    shiftKind_e       kind;
    logic [AMT_W-1:0] amount;
    logic             amountZero;
    logic             commit;
  } strobes_t;

endpackage

// File: rtl/o2_ctrl.sv
module o2_ctrl
  import o2_pkg::*;
(
  input  logic [7:0]       fieldHi,   // operand field bits 11:4
  input  logic             immFlag,
  input  logic [AMT_W-1:0] rsByte,
  input  logic             setFlags,
  input  logic [1:0]       useKind,
  output strobes_t         strb
);

  // positions relative to bit 4 of the operand field
  localparam int SRC_BIT  = 0;
  localparam int TYPE_LSB = 1;
  localparam int IAMT_LSB = 3;
  localparam int IAMT_W   = 5;
  localparam int ROT_LSB  = 4;

  logic [AMT_W-1:0] amountSel;

  always_comb begin
    if (fieldHi[SRC_BIT]) amountSel = rsByte;
    else                  amountSel = AMT_W'(fieldHi[IAMT_LSB +: IAMT_W]);
  end

  always_comb begin
    strb.immMode    = immFlag;
    strb.rotField   = fieldHi[ROT_LSB +: ROT_W];
    strb.kind       = shiftKind_e'(fieldHi[TYPE_LSB +: 2]);
    strb.amount     = amountSel;
    strb.amountZero = (amountSel == '0);
    case (useKind_e'(useKind))
      USE_ALU:  strb.commit = setFlags;
      USE_TEST: strb.commit = 1'b1;
      default:  strb.commit = 1'b0;
    endcase
  end

endmodule

// File: rtl/o2_datapath.sv
module o2_datapath
  import o2_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [7:0]        immByte,
  input  logic [DATA_W-1:0] rmValue,
  input  logic              carryIn,
  output logic [DATA_W-1:0] operand,
  output logic              carryOut,
  output logic              carryValid
);

  localparam int SH_W  = $clog2(DATA_W);
  localparam int EXT_W = 2 * DATA_W;

  function automatic logic [DATA_W-1:0] rotr(input logic [DATA_W-1:0] v,
                                              input logic [SH_W-1:0] k);
    logic [EXT_W-1:0] d;
    d = {v, v} >> k;
    return d[DATA_W-1:0];
  endfunction

  // immediate path
  logic [DATA_W-1:0] immRes;
  always_comb immRes = rotr(DATA_W'(immByte), SH_W'({strb.rotField, 1'b0}));

  // register path
  logic [SH_W-1:0]          amtLow;
  logic                     inRange;
  logic                     exactW;
  logic [EXT_W-1:0]         lslExt;
  logic [EXT_W-1:0]         lsrExt;
  logic signed [EXT_W-1:0]  asrExt;
  logic [DATA_W-1:0]        rorRes;

  always_comb begin
    amtLow  = strb.amount[SH_W-1:0];
    inRange = (strb.amount < AMT_W'(DATA_W));
    exactW  = (strb.amount == AMT_W'(DATA_W));
    lslExt  = {{DATA_W{1'b0}}, rmValue} << amtLow;
    lsrExt  = {rmValue, {DATA_W{1'b0}}} >> amtLow;
    asrExt  = $signed({rmValue, {DATA_W{1'b0}}}) >>> amtLow;
    rorRes  = rotr(rmValue, amtLow);
  end

  logic [DATA_W-1:0] nextOp;
  logic              nextC;

  always_comb begin
    nextOp = rmValue;
    nextC  = carryIn;
    if (strb.immMode) begin
      nextOp = immRes;
      nextC  = (strb.rotField == '0) ? carryIn : immRes[DATA_W-1];
    end else if (!strb.amountZero) begin
      case (strb.kind)
        SH_LSL: begin
          if (inRange) begin
            nextOp = lslExt[DATA_W-1:0];
            nextC  = lslExt[DATA_W];
          end else begin
            nextOp = '0;
            nextC  = exactW ? rmValue[0] : 1'b0;
          end
        end
        SH_LSR: begin
          if (inRange) begin
            nextOp = lsrExt[EXT_W-1:DATA_W];
            nextC  = lsrExt[DATA_W-1];
          end else begin
            nextOp = '0;
            nextC  = exactW ? rmValue[DATA_W-1] : 1'b0;
          end
        end
        SH_ASR: begin
          if (inRange) begin
            nextOp = asrExt[EXT_W-1:DATA_W];
            nextC  = asrExt[DATA_W-1];
          end else begin
            nextOp = {DATA_W{rmValue[DATA_W-1]}};
            nextC  = rmValue[DATA_W-1];
          end
        end
        default: begin
          nextOp = rorRes;
          nextC  = rorRes[DATA_W-1];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      operand    <= '0;
      carryOut   <= 1'b0;
      carryValid <= 1'b0;
    end else begin
      operand    <= nextOp;
      carryOut   <= nextC;
      carryValid <= strb.commit;
    end
  end

  AST_ZERO_PASSTHRU: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.immMode && strb.amountZero) |=>
      (operand == $past(rmValue) && carryOut == $past(carryIn))); // R4

  AST_LOGICAL_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.immMode && (strb.kind == SH_LSL || strb.kind == SH_LSR) &&
     strb.amount > AMT_W'(DATA_W)) |=> (operand == '0 && !carryOut)); // R6

  AST_ASR_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.immMode && strb.kind == SH_ASR && !inRange) |=>
      (operand == {DATA_W{$past(rmValue[DATA_W-1])}})); // R7

  AST_ROR_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.immMode && strb.kind == SH_ROR) |=>
      ($countones(operand) == $countones($past(rmValue)))); // R8

endmodule

// File: rtl/o2_shifter.sv
module o2_shifter
  import o2_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [11:0]       opField,
  input  logic              immFlag,
  input  logic [DATA_W-1:0] rmValue,
  input  logic [AMT_W-1:0]  rsByte,
  input  logic              carryIn,
  input  logic              setFlags,
  input  logic [1:0]        useKind,
  output logic [DATA_W-1:0] operand,
  output logic              carryOut,
  output logic              carryValid
);

  strobes_t strb;

  o2_ctrl u_ctrl (
    .fieldHi  (opField[11:4]),
    .immFlag  (immFlag),
    .rsByte   (rsByte),
    .setFlags (setFlags),
    .useKind  (useKind),
    .strb     (strb)
  );

  o2_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .immByte    (opField[7:0]),
    .rmValue    (rmValue),
    .carryIn    (carryIn),
    .operand    (operand),
    .carryOut   (carryOut),
    .carryValid (carryValid)
  );

  AST_ADDR_NO_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    useKind[1] |=> !carryValid); // R9

  AST_TEST_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (useKind == 2'b01) |=> carryValid); // R9

endmodule

// File: tb/tb_o2_shifter.sv
module tb_o2_shifter;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] opField = '0;
  logic        immFlag = 1'b0;
  logic [31:0] rmValue = '0;
  logic [7:0]  rsByte = '0;
  logic        carryIn = 1'b0;
  logic        setFlags = 1'b0;
  logic [1:0]  useKind = 2'b00;
  logic [31:0] operand;
  logic        carryOut;
  logic        carryValid;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  o2_shifter dut (
    .clk(clk), .rstN(rstN), .opField(opField), .immFlag(immFlag),
    .rmValue(rmValue), .rsByte(rsByte), .carryIn(carryIn),
    .setFlags(setFlags), .useKind(useKind), .operand(operand),
    .carryOut(carryOut), .carryValid(carryValid)
  );

  // Reference model: one bit at a time, written from the requirements
  task automatic model(input logic [11:0] f, input logic imm, input logic [31:0] rm,
                       input logic [7:0] rs, input logic cin, input logic sf,
                       input logic [1:0] uk, output logic [31:0] eo,
                       output logic ec, output logic ev);
    logic [31:0] v;
    logic c;
    int n;
    c = cin;
    if (imm) begin
      v = {24'h0, f[7:0]};
      n = 2 * int'(f[11:8]);
      for (int i = 0; i < n; i++) v = {v[0], v[31:1]};
      if (n != 0) c = v[31];
    end else begin
      v = rm;
      n = f[4] ? int'(rs) : int'(f[11:7]);
      for (int i = 0; i < n; i++) begin
        case (f[6:5])
          2'b00: begin c = v[31]; v = {v[30:0], 1'b0}; end
          2'b01: begin c = v[0];  v = {1'b0, v[31:1]}; end
          2'b10: begin c = v[0];  v = {v[31], v[31:1]}; end
          default: begin c = v[0]; v = {v[0], v[31:1]}; end
        endcase
      end
    end
    eo = v;
    ec = c;
    ev = (uk == 2'b00) ? sf : (uk == 2'b01);
  endtask

  task automatic check(input string tag, input logic [31:0] eo, input logic ec,
                       input logic ev);
    checks++;
    if (operand !== eo || carryOut !== ec || carryValid !== ev) begin
      fails++;
      $display("FAIL %s: got op=%h c=%b v=%b, expected op=%h c=%b v=%b",
               tag, operand, carryOut, carryValid, eo, ec, ev);
    end
  endtask

  task automatic apply(input string tag, input logic [11:0] f, input logic imm,
                       input logic [31:0] rm, input logic [7:0] rs, input logic cin,
                       input logic sf, input logic [1:0] uk);
    logic [31:0] eo;
    logic ec, ev;
    model(f, imm, rm, rs, cin, sf, uk, eo, ec, ev);
    @(negedge clk);
    opField = f; immFlag = imm; rmValue = rm; rsByte = rs;
    carryIn = cin; setFlags = sf; useKind = uk;
    @(posedge clk);
    #1;
    check(tag, eo, ec, ev);
  endtask

  function automatic logic [11:0] immAmt(input logic [4:0] a, input logic [1:0] t);
    return {a, t, 1'b0, 4'h0};
  endfunction

  function automatic logic [11:0] regAmt(input logic [1:0] t);
    return {4'h3, 1'b0, t, 1'b1, 4'h0};
  endfunction

  task automatic test_reset;
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R10 reset", 32'h0, 1'b0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic test_immediate;
    apply("R1 rot0 cin1", 12'h0A5, 1'b1, 32'hFFFF_FFFF, 8'd0, 1'b1, 1'b1, 2'b00);
    apply("R1 rot0 cin0", 12'h0FF, 1'b1, 32'h0, 8'd0, 1'b0, 1'b1, 2'b00);
    apply("R1 rot1",      12'h1C3, 1'b1, 32'h0, 8'd0, 1'b0, 1'b1, 2'b00);
    apply("R1 rot4",      12'h4F0, 1'b1, 32'h0, 8'd0, 1'b1, 1'b1, 2'b00);
    apply("R1 rot15",     12'hF81, 1'b1, 32'h0, 8'd0, 1'b0, 1'b1, 2'b00);
  endtask

  task automatic test_small_shifts;
    for (int t = 0; t < 4; t++) begin
      apply("R2 amt1",  immAmt(5'd1,  2'(t)), 1'b0, 32'h8000_0001, 8'hFF, 1'b0, 1'b1, 2'b00);
      apply("R5 amt5",  immAmt(5'd5,  2'(t)), 1'b0, 32'hC3A5_5A3C, 8'hFF, 1'b1, 1'b1, 2'b00);
      apply("R5 amt31", immAmt(5'd31, 2'(t)), 1'b0, 32'h9234_5679, 8'h00, 1'b0, 1'b1, 2'b00);
      apply("R3 reg amt7", regAmt(2'(t)), 1'b0, 32'hF00D_BEEF, 8'd7, 1'b0, 1'b1, 2'b00);
    end
  endtask

  task automatic test_zero_amount;
    for (int t = 0; t < 4; t++) begin
      apply("R4 imm zero c1", immAmt(5'd0, 2'(t)), 1'b0, 32'h8765_4321, 8'd9, 1'b1, 1'b1, 2'b00);
      apply("R4 imm zero c0", immAmt(5'd0, 2'(t)), 1'b0, 32'hFFFF_FFFF, 8'd9, 1'b0, 1'b1, 2'b00);
      apply("R4 reg zero",    regAmt(2'(t)),       1'b0, 32'h8000_0001, 8'd0, 1'b1, 1'b1, 2'b00);
    end
  endtask

  task automatic test_large_logical;
    apply("R6 lsl 32 bit0=1", regAmt(2'b00), 1'b0, 32'h0000_0001, 8'd32,  1'b0, 1'b1, 2'b00);
    apply("R6 lsl 32 bit0=0", regAmt(2'b00), 1'b0, 32'hFFFF_FFFE, 8'd32,  1'b1, 1'b1, 2'b00);
    apply("R6 lsl 33",        regAmt(2'b00), 1'b0, 32'hFFFF_FFFF, 8'd33,  1'b1, 1'b1, 2'b00);
    apply("R6 lsl 200",       regAmt(2'b00), 1'b0, 32'hFFFF_FFFF, 8'd200, 1'b1, 1'b1, 2'b00);
    apply("R6 lsr 32",        regAmt(2'b01), 1'b0, 32'h8000_0000, 8'd32,  1'b0, 1'b1, 2'b00);
    apply("R6 lsr 40",        regAmt(2'b01), 1'b0, 32'hFFFF_FFFF, 8'd40,  1'b1, 1'b1, 2'b00);
    apply("R7 asr 32 neg",    regAmt(2'b10), 1'b0, 32'h8000_1234, 8'd32,  1'b0, 1'b1, 2'b00);
    apply("R7 asr 100 pos",   regAmt(2'b10), 1'b0, 32'h7FFF_FFFF, 8'd100, 1'b1, 1'b1, 2'b00);
    apply("R7 asr 255 neg",   regAmt(2'b10), 1'b0, 32'hC000_0000, 8'd255, 1'b0, 1'b1, 2'b00);
  endtask

  task automatic test_rotate_reg;
    apply("R8 ror 32 neg", regAmt(2'b11), 1'b0, 32'h8123_4567, 8'd32,  1'b0, 1'b1, 2'b00);
    apply("R8 ror 64 pos", regAmt(2'b11), 1'b0, 32'h7123_4567, 8'd64,  1'b1, 1'b1, 2'b00);
    apply("R8 ror 36",     regAmt(2'b11), 1'b0, 32'h1234_5678, 8'd36,  1'b0, 1'b1, 2'b00);
    apply("R8 ror 255",    regAmt(2'b11), 1'b0, 32'h0000_0003, 8'd255, 1'b0, 1'b1, 2'b00);
  endtask

  task automatic test_commit;
    for (int uk = 0; uk < 4; uk++) begin
      for (int sf = 0; sf < 2; sf++) begin
        apply("R9 commit", immAmt(5'd3, 2'b01), 1'b0, 32'h0000_0007, 8'd0, 1'b0,
              1'(sf), 2'(uk));
      end
    end
    apply("R9 addr imm", 12'h2FF, 1'b1, 32'h0, 8'd0, 1'b1, 1'b1, 2'b10);
  endtask

  task automatic test_timing;
    logic [31:0] eo;
    logic ec, ev;
    apply("R10 first", immAmt(5'd4, 2'b00), 1'b0, 32'h0000_00F1, 8'd0, 1'b0, 1'b1, 2'b00);
    model(immAmt(5'd4, 2'b00), 1'b0, 32'h0000_00F1, 8'd0, 1'b0, 1'b1, 2'b00, eo, ec, ev);
    @(negedge clk);
    rmValue = 32'hFFFF_0000; useKind = 2'b10;
    #1;
    check("R10 holds until edge", eo, ec, ev);
    model(immAmt(5'd4, 2'b00), 1'b0, 32'hFFFF_0000, 8'd0, 1'b0, 1'b1, 2'b10, eo, ec, ev);
    @(posedge clk);
    #1;
    check("R10 updates at edge", eo, ec, ev);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    test_reset();
    test_immediate();
    test_small_shifts();
    test_zero_amount();
    test_large_logical();
    test_rotate_reg();
    test_commit();
    test_timing();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule